// File: doc/BRIEF.md
# Pair-and-Spare Board Fault Controller

This block supervises two self-checking processor boards that run as a pair and a spare. Every board carries two halves fed by one clock. Each half offers a data word to one of two shared buses: half A to bus A, half B to bus B. The block compares the two halves of each board in every cycle. A board that passes the comparison drives its halves onto the buses, and each bus is the OR of all the halves that are driving it. A board whose halves disagree loses its drivers in that same cycle and is marked failed. The block then raises a maintenance interrupt and lights the board's fault lamp. From then on the surviving board drives both buses alone.

Monitors on the memory side may declare a bus dead. After that, no board drives the dead bus, and receiver errors reported on it are ignored. A receiver error on a live bus points to the board itself, so the board is failed. Software brings a failed board or a newly inserted board into a resynchronisation state. A completion strobe then returns the board to service. A fault that would leave no board in service raises a sticky system-halt flag instead of removing boards.

Top module: `pair_spare_guard`

## Requirements
- R1: Each ONLINE board whose half A and half B words differ goes to FAILED on the next clock edge. Per-board state codes are OFFLINE=0, ONLINE=1, FAILED=2, RESYNC=3, and board_state[1:0] holds board 0 and board_state[3:2] holds board 1.
- R2: A board drives a bus only while it is ONLINE and its halves agree. The drive enable falls in the same cycle as the mismatch. Each bus carries the OR of the half words whose drive enable is high, and it is zero when no half drives it.
- R3: When a board enters FAILED, its maint_irq bit pulses high for exactly one cycle. Its fault_lamp bit stays high for as long as the board stays FAILED.
- R4: With one board out of service, the remaining ONLINE board alone drives both bus A and bus B.
- R5: A bus_broken strobe (bit 0 for bus A, bit 1 for bus B) sets the matching bus_dead bit on the next edge. No board drives a dead bus. A bus_fix strobe clears the bit.
- R6: A receiver error reported by an ONLINE board on a live bus fails that board. A receiver error on a dead bus has no effect.
- R7: sw_resync moves a FAILED board to RESYNC. It also moves an OFFLINE board to RESYNC when that board is present. It has no effect on an ONLINE board or on an absent board. A RESYNC board drives nothing.
- R8: sync_done moves a RESYNC board to ONLINE. It has no effect in any other state.
- R9: A board whose present input is low goes to OFFLINE on the next edge, whatever its state.
- R10: A fault that would leave no board ONLINE without a fault sets sys_halt, which stays set until reset. No board changes state for that fault, and all drive enables stay low while sys_halt is set.
- R11: After reset both boards are ONLINE, and no bus is dead, sys_halt is low, and all interrupt and lamp bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| brd_present | input | 2 | Board inserted, one bit per board |
| half_a_0 | input | DATA_W | Board 0 half A word |
| half_b_0 | input | DATA_W | Board 0 half B word |
| half_a_1 | input | DATA_W | Board 1 half A word |
| half_b_1 | input | DATA_W | Board 1 half B word |
| rx_err_a | input | 2 | Per-board receiver inconsistency seen on bus A |
| rx_err_b | input | 2 | Per-board receiver inconsistency seen on bus B |
| bus_broken | input | 2 | Strobe from parity monitors declaring bus A (bit 0) or B (bit 1) dead |
| bus_fix | input | 2 | Strobe from software clearing a dead bus |
| sw_resync | input | 2 | Per-board software request to start resynchronisation |
| sync_done | input | 2 | Per-board resynchronisation complete strobe |
| bus_a | output | DATA_W | Bus A value, OR of driving halves |
| bus_b | output | DATA_W | Bus B value, OR of driving halves |
| drv_en_a | output | 2 | Per-board bus A driver enable |
| drv_en_b | output | 2 | Per-board bus B driver enable |
| board_state | output | 4 | Packed per-board state codes |
| maint_irq | output | 2 | Per-board one-cycle maintenance interrupt |
| fault_lamp | output | 2 | Per-board red fault indicator |
| bus_dead | output | 2 | Dead flags for bus A (bit 0) and B (bit 1) |
| sys_halt | output | 1 | Sticky halt when no board could remain in service |

## Verification
The checker relies on one assumption about the inputs: the half words, error flags and strobes change only away from the active edge and are synchronous to the clock. Given that, a same-cycle comparison between a drive enable and the matching half words is meaningful. The bench changes every input on the falling edge and holds each strobe for exactly one cycle. It samples the combinational bus and enable outputs one nanosecond after the inputs change, and it samples the registered state one nanosecond after the rising edge.

// File: rtl/pns_pkg.sv
package pns_pkg;
  localparam int NUM_BRD = 2;

  typedef enum logic [1:0] {
    BRD_OFFLINE = 2'd0,
    BRD_ONLINE  = 2'd1,
    BRD_FAILED  = 2'd2,
    BRD_RESYNC  = 2'd3
  } brd_st_e;
endpackage

// File: rtl/pns_fault_detect.sv
module pns_fault_detect #(
  parameter int DATA_W = 8
) (
  input  logic              online,
  input  logic              chk_en,
  input  logic [DATA_W-1:0] half_a,
  input  logic [DATA_W-1:0] half_b,
  input  logic              rx_err_a,
  input  logic              rx_err_b,
  input  logic              dead_a,
  input  logic              dead_b,
  output logic              fault_now
);
  logic miscompare;
  logic rx_blame;

  always_comb begin
    miscompare = (half_a != half_b);
    rx_blame   = (rx_err_a & ~dead_a) | (rx_err_b & ~dead_b);
    fault_now  = online & chk_en & (miscompare | rx_blame);
  end
endmodule

// File: rtl/pns_board_fsm.sv
module pns_board_fsm
  import pns_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    present,
  input  logic    fail_go,
  input  logic    resync_req,
  input  logic    sync_done,
  output brd_st_e state,
  output logic    irq
);
  brd_st_e st_d;
  logic    irq_d;

  always_comb begin
    st_d = state;
    if (!present) begin
      st_d = BRD_OFFLINE;
    end else begin
      unique case (state)
        BRD_ONLINE:  if (fail_go)    st_d = BRD_FAILED;
        BRD_FAILED:  if (resync_req) st_d = BRD_RESYNC;
        BRD_OFFLINE: if (resync_req) st_d = BRD_RESYNC;
        BRD_RESYNC:  if (sync_done)  st_d = BRD_ONLINE;
        default:     st_d = state;
      endcase
    end
    irq_d = (state == BRD_ONLINE) && (st_d == BRD_FAILED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= BRD_ONLINE;
      irq   <= 1'b0;
    end else begin
      state <= st_d;
      irq   <= irq_d;
    end
  end
endmodule

// File: rtl/pns_bus_health.sv
module pns_bus_health #(
  parameter int NUM_BUS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_BUS-1:0] broken,
  input  logic [NUM_BUS-1:0] fix,
  output logic [NUM_BUS-1:0] dead
);
  logic [NUM_BUS-1:0] dead_d;

  always_comb begin
    for (int k = 0; k < NUM_BUS; k++) begin
      if (broken[k])   dead_d[k] = 1'b1;
      else if (fix[k]) dead_d[k] = 1'b0;
      else             dead_d[k] = dead[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dead <= '0;
    else        dead <= dead_d;
  end
endmodule

// File: rtl/pair_spare_guard.sv
module pair_spare_guard
  import pns_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        brd_present,
  input  logic [DATA_W-1:0] half_a_0,
  input  logic [DATA_W-1:0] half_b_0,
  input  logic [DATA_W-1:0] half_a_1,
  input  logic [DATA_W-1:0] half_b_1,
  input  logic [1:0]        rx_err_a,
  input  logic [1:0]        rx_err_b,
  input  logic [1:0]        bus_broken,
  input  logic [1:0]        bus_fix,
  input  logic [1:0]        sw_resync,
  input  logic [1:0]        sync_done,
  output logic [DATA_W-1:0] bus_a,
  output logic [DATA_W-1:0] bus_b,
  output logic [1:0]        drv_en_a,
  output logic [1:0]        drv_en_b,
  output logic [3:0]        board_state,
  output logic [1:0]        maint_irq,
  output logic [1:0]        fault_lamp,
  output logic [1:0]        bus_dead,
  output logic              sys_halt
);
  localparam int NB    = NUM_BRD;
  localparam int NBUS  = 2;
  localparam int ST_W  = $bits(brd_st_e);

  logic                       rst_meta, rst_sync;
  logic [NB-1:0][DATA_W-1:0]  ha, hb;
  logic [NB-1:0]              online, fault_now, fail_go;
  brd_st_e                    st [NB];
  logic                       halt_set, halt_d;

  // reset: asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign ha[0] = half_a_0;
  assign hb[0] = half_b_0;
  assign ha[1] = half_a_1;
  assign hb[1] = half_b_1;

  pns_bus_health #(.NUM_BUS(NBUS)) u_health (
    .clk    (clk),
    .rst_n  (rst_sync),
    .broken (bus_broken),
    .fix    (bus_fix),
    .dead   (bus_dead)
  );

  for (genvar b = 0; b < NB; b++) begin : g_brd
    pns_fault_detect #(.DATA_W(DATA_W)) u_det (
      .online    (online[b]),
      .chk_en    (~sys_halt),
      .half_a    (ha[b]),
      .half_b    (hb[b]),
      .rx_err_a  (rx_err_a[b]),
      .rx_err_b  (rx_err_b[b]),
      .dead_a    (bus_dead[0]),
      .dead_b    (bus_dead[1]),
      .fault_now (fault_now[b])
    );

    pns_board_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_sync),
      .present    (brd_present[b]),
      .fail_go    (fail_go[b]),
      .resync_req (sw_resync[b]),
      .sync_done  (sync_done[b]),
      .state      (st[b]),
      .irq        (maint_irq[b])
    );

    assign online[b]                     = (st[b] == BRD_ONLINE);
    assign fail_go[b]                    = fault_now[b] & ~halt_set;
    assign fault_lamp[b]                 = (st[b] == BRD_FAILED);
    assign board_state[b*ST_W +: ST_W]   = st[b];
    assign drv_en_a[b] = online[b] & ~fault_now[b] & ~sys_halt & ~bus_dead[0];
    assign drv_en_b[b] = online[b] & ~fault_now[b] & ~sys_halt & ~bus_dead[1];
  end

  // a fault leaving no healthy online board halts instead of removing
  always_comb begin
    halt_set = (|fault_now) & ~(|(online & ~fault_now));
    halt_d   = sys_halt | halt_set;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) sys_halt <= 1'b0;
    else           sys_halt <= halt_d;
  end

  // wired-OR of enabled halves
  always_comb begin
    bus_a = '0;
    bus_b = '0;
    for (int b = 0; b < NB; b++) begin
      if (drv_en_a[b]) bus_a = bus_a | ha[b];
      if (drv_en_b[b]) bus_b = bus_b | hb[b];
    end
  end
endmodule

// File: rtl/pair_spare_guard_chk.sv
module pair_spare_guard_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        brd_present,
  input logic [DATA_W-1:0] half_a_0,
  input logic [DATA_W-1:0] half_b_0,
  input logic [DATA_W-1:0] half_a_1,
  input logic [DATA_W-1:0] half_b_1,
  input logic [1:0]        rx_err_a,
  input logic [1:0]        rx_err_b,
  input logic [1:0]        bus_broken,
  input logic [1:0]        bus_fix,
  input logic [1:0]        sw_resync,
  input logic [1:0]        sync_done,
  input logic [DATA_W-1:0] bus_a,
  input logic [DATA_W-1:0] bus_b,
  input logic [1:0]        drv_en_a,
  input logic [1:0]        drv_en_b,
  input logic [3:0]        board_state,
  input logic [1:0]        maint_irq,
  input logic [1:0]        fault_lamp,
  input logic [1:0]        bus_dead,
  input logic              sys_halt
);
  // R2
  brd0_drive_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en_a[0] | drv_en_b[0]) |-> (half_a_0 == half_b_0));
  // R2
  brd1_drive_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en_a[1] | drv_en_b[1]) |-> (half_a_1 == half_b_1));
  // R5
  dead_a_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dead[0] |-> (drv_en_a == 2'b00));
  // R5
  dead_b_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dead[1] |-> (drv_en_b == 2'b00));
  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_halt |=> sys_halt);
  // R10
  halt_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_halt |-> ((drv_en_a | drv_en_b) == 2'b00));
  // R3
  irq0_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    maint_irq[0] |=> !maint_irq[0]);
  // R3
  irq1_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    maint_irq[1] |=> !maint_irq[1]);
  // R3
  irq_lamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((maint_irq & ~fault_lamp) == 2'b00));
  // R7
  failed_not_online_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (board_state[1:0] == 2'd2) |=> (board_state[1:0] != 2'd1));
endmodule

bind pair_spare_guard pair_spare_guard_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/pair_spare_guard_tb.sv
module pair_spare_guard_tb;
  localparam int W = 8;

  logic         clk, rst_n;
  logic [1:0]   brd_present, rx_err_a, rx_err_b, bus_broken, bus_fix;
  logic [1:0]   sw_resync, sync_done;
  logic [W-1:0] half_a_0, half_b_0, half_a_1, half_b_1;
  logic [W-1:0] bus_a, bus_b;
  logic [1:0]   drv_en_a, drv_en_b, maint_irq, fault_lamp, bus_dead;
  logic [3:0]   board_state;
  logic         sys_halt;

  pair_spare_guard #(.DATA_W(W)) u_dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    string       req;
    int          sel;
    logic [15:0] exp;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    checks = 0;
  int    failures = 0;
  bit    done = 0;

  function automatic logic [15:0] actual(int sel);
    case (sel)
      0: return 16'(bus_a);
      1: return 16'(bus_b);
      2: return {12'd0, drv_en_a, drv_en_b};
      3: return {12'd0, board_state};
      4: return {14'd0, fault_lamp};
      5: return {14'd0, maint_irq};
      6: return {15'd0, sys_halt};
      default: return {14'd0, bus_dead};
    endcase
  endfunction

  // monitor: drains the scoreboard each time the driver posts items
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it  = q.pop_front();
        act = actual(it.sel);
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic expect_v(string req, int sel, logic [15:0] val);
    item_t it;
    it.req = req; it.sel = sel; it.exp = val;
    q.push_back(it);
    ->chk_ev;
    #0;
  endtask

  task automatic at_neg();
    @(negedge clk);
    bus_broken = 0; bus_fix = 0; sw_resync = 0; sync_done = 0;
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic set_all(logic [W-1:0] v);
    half_a_0 = v; half_b_0 = v; half_a_1 = v; half_b_1 = v;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; brd_present = 2'b11; rx_err_a = 0; rx_err_b = 0;
    bus_broken = 0; bus_fix = 0; sw_resync = 0; sync_done = 0;
    set_all(8'h00);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    expect_v("R11 states", 3, 16'h5);
    expect_v("R11 halt", 6, 0);
    expect_v("R11 lamp", 4, 0);
    expect_v("R11 dead", 7, 0);
    expect_v("R11 drv", 2, 16'hF);

    // R2 normal wired-OR
    at_neg(); set_all(8'h3C); #1;
    expect_v("R2 bus_a", 0, 16'h3C);
    expect_v("R2 bus_b", 1, 16'h3C);

    // R1 R2 mismatch on board 0
    at_neg(); half_b_0 = 8'h3D; #1;
    expect_v("R2 same-cycle drop", 2, 16'hA);
    expect_v("R2 bus_b clean", 1, 16'h3C);
    after_edge();
    expect_v("R1 board0 failed", 3, 16'h6);
    expect_v("R3 irq", 5, 16'h1);
    expect_v("R3 lamp", 4, 16'h1);
    after_edge();
    expect_v("R3 irq one cycle", 5, 0);
    expect_v("R3 lamp held", 4, 16'h1);

    // R4 survivor drives both buses
    at_neg(); half_b_0 = 8'h3C; half_a_1 = 8'h55; half_b_1 = 8'h55; #1;
    expect_v("R4 drv", 2, 16'hA);
    expect_v("R4 bus_a", 0, 16'h55);
    expect_v("R4 bus_b", 1, 16'h55);
    set_all(8'h55);

    // R7 resync board 0, R8 done
    at_neg(); sw_resync = 2'b01; after_edge();
    expect_v("R7 resync", 3, 16'h7);
    expect_v("R7 resync no drive", 2, 16'hA);
    at_neg(); sw_resync = 2'b10; after_edge();
    expect_v("R7 ignored online", 3, 16'h7);
    at_neg(); sync_done = 2'b01; after_edge();
    expect_v("R8 back online", 3, 16'h5);
    expect_v("R8 drv", 2, 16'hF);

    // R5 bus A dead
    at_neg(); bus_broken = 2'b01; after_edge();
    expect_v("R5 dead", 7, 16'h1);
    expect_v("R5 drv", 2, 16'h3);
    expect_v("R5 bus_a quiet", 0, 0);
    // R6 error on dead bus ignored
    at_neg(); rx_err_a = 2'b10; after_edge();
    expect_v("R6 ignored dead", 3, 16'h5);
    at_neg(); rx_err_a = 0; rx_err_b = 2'b10; #1;
    expect_v("R6 drop live", 2, 16'h1);
    after_edge();
    expect_v("R6 board1 failed", 3, 16'h9);
    expect_v("R6 irq", 5, 16'h2);
    at_neg(); rx_err_b = 0; bus_fix = 2'b01; after_edge();
    expect_v("R5 fixed", 7, 0);
    expect_v("R5 drv after fix", 2, 16'h5);
    at_neg(); sw_resync = 2'b10; after_edge();
    at_neg(); sync_done = 2'b10; after_edge();
    expect_v("R8 board1 online", 3, 16'h5);

    // R9 removal and reinsertion
    at_neg(); brd_present = 2'b01; after_edge();
    expect_v("R9 offline", 3, 16'h1);
    expect_v("R9 drv", 2, 16'h5);
    at_neg(); sync_done = 2'b10; after_edge();
    expect_v("R8 ignored offline", 3, 16'h1);
    at_neg(); sw_resync = 2'b10; after_edge();
    expect_v("R7 ignored absent", 3, 16'h1);
    at_neg(); brd_present = 2'b11; after_edge();
    expect_v("R9 still offline", 3, 16'h1);
    at_neg(); sw_resync = 2'b10; after_edge();
    expect_v("R7 insert resync", 3, 16'hD);
    at_neg(); sync_done = 2'b10; after_edge();
    expect_v("R8 inserted online", 3, 16'h5);

    // R10 double fault
    at_neg(); half_b_0 = 8'h11; half_b_1 = 8'h22; #1;
    expect_v("R10 drv off", 2, 16'h0);
    after_edge();
    expect_v("R10 halt", 6, 16'h1);
    expect_v("R10 states kept", 3, 16'h5);
    expect_v("R10 no lamp", 4, 0);
    at_neg(); set_all(8'h55); after_edge();
    expect_v("R10 halt sticky", 6, 16'h1);
    expect_v("R10 drv stays off", 2, 16'h0);
    expect_v("R10 bus quiet", 0, 0);

    #1;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule